// File: doc/BRIEF.md
# Break-Bit Issue Grouper with Block Predication

This block takes one decoded instruction block that carries a parallelism header and issues its instruction slots as parallel groups, one group per clock. The header occupies slot 0. It gives a break bit for each of the seven following slots, a 4-bit selector that picks one of sixteen predication flags, a 7-bit mask of the conditionally executed slots, a sense bit, and a 3-bit count of trailing slots that hold data rather than instructions. With each group the block also drives an execute-enable for every slot. The enable applies the predication rule, using the flag value captured when the block was accepted.

A block is accepted through a valid/ready handshake. Groups then appear on consecutive cycles, from the lowest slot upwards, and a single-cycle done pulse follows the last group. When the serial-mode input is high at acceptance, the break bits are disregarded and each slot forms a group of its own. This matches a simple in-order core that runs one instruction at a time.

Top module: `slot_issue_grouper`

## Requirements
- R1: After reset, in_ready is 1 and issue_valid, done, issue_mask and exec_en are all 0.
- R2: in_ready is 1 only while the block is idle. A block is accepted at a rising edge where in_valid and in_ready are both 1, and its first group (or its done pulse, if it has no slots) appears in the next cycle.
- R3: Bit i of hdr_break, issue_mask, exec_en and hdr_pred refers to instruction slot i+1. When bit i of hdr_break is set (i greater than 0), slot i+1 starts a new group. Bit 0 of hdr_break has no effect.
- R4: Groups are issued one per clock with no gaps, in ascending slot order. Each group is a contiguous, non-empty run of slots, and every non-reserved slot is issued exactly once.
- R5: A value d on hdr_decode reserves the last d slots, and those slots are never issued. A value of 7 yields a block with no groups.
- R6: When serial_mode is 1 at acceptance, every group holds exactly one slot and the break bits are disregarded. A later change of serial_mode has no effect on the accepted block.
- R7: exec_en bit i is 1 exactly when slot i+1 is issued and either hdr_pred bit i is 0 or the selected flag differs from hdr_sense. So with sense 0, the slot runs only if the flag is 1, and with sense 1, only if the flag is 0.
- R8: The flag selected by hdr_flag_sel is sampled at acceptance, and changes on flags afterwards do not affect that block's exec_en.
- R9: done is high for exactly one cycle, the cycle after the last group, and in_ready is 1 in the cycle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| serial_mode | input | 1 | Issue one slot per group, sampled at acceptance |
| in_valid | input | 1 | Header fields are valid |
| in_ready | output | 1 | Block can accept a header |
| hdr_break | input | NSLOT | Break bit per instruction slot |
| hdr_flag_sel | input | log2(NFLAG) | Index of the predication flag |
| hdr_pred | input | NSLOT | Slots that execute conditionally |
| hdr_sense | input | 1 | 0: execute when flag is 1; 1: execute when flag is 0 |
| hdr_decode | input | log2(NSLOT+1) | Number of trailing reserved slots |
| flags | input | NFLAG | Current predication flag register |
| issue_valid | output | 1 | A group is presented this cycle |
| issue_mask | output | NSLOT | Slots in the current group |
| exec_en | output | NSLOT | Per-slot execute-enable after predication |
| done | output | 1 | One-cycle pulse after the last group |

## Verification
A stale slot pointer or a wrong captured limit is visible in the very next group. A slot then repeats, gets skipped, or lands in a reserved position, and the in-order scoreboard catches it at the first mismatching group. A captured flag or sense bit that was taken at the wrong time only shows on predicated slots. For that reason the flags are inverted right after acceptance, so a late sample flips exec_en in the first group. A state machine that lingers or stops early shows up within one cycle as a missing group, an extra group, or a misplaced done pulse or ready.

// File: rtl/sig_pkg.sv
package sig_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DONE  = 2'd2
  } sig_state_e;
endpackage

// File: rtl/sig_group_span.sv
// Forms the next issue group: a run of slots starting at start_ptr that
// closes before the next set break bit (or after one slot in serial mode)
// and never reaches past the last usable slot.
module sig_group_span #(
  parameter int NSLOT = 7,
  parameter int CNT_W = 3
) (
  input  logic [CNT_W-1:0] start_ptr,
  input  logic [CNT_W-1:0] limit,
  input  logic [NSLOT-1:0] brk,
  input  logic             serial,
  output logic [NSLOT-1:0] mask,
  output logic [CNT_W-1:0] next_ptr,
  output logic             last
);
  logic             run_open;
  logic [CNT_W-1:0] run_cnt;

  always_comb begin
    run_open = 1'b0;
    run_cnt  = '0;
    mask     = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (CNT_W'(i) == start_ptr) begin
        run_open = 1'b1;
      end else if (brk[i] || serial) begin
        run_open = 1'b0;
      end
      if (CNT_W'(i) >= limit) begin
        run_open = 1'b0;
      end
      mask[i] = run_open;
      run_cnt = run_cnt + CNT_W'(run_open);
    end
    next_ptr = start_ptr + run_cnt;
    last     = (next_ptr >= limit);
  end
endmodule

// File: rtl/sig_pred_gate.sv
// Applies the block-wide predicate to the slots of the current group.
module sig_pred_gate #(
  parameter int NSLOT = 7
) (
  input  logic [NSLOT-1:0] issue_mask,
  input  logic [NSLOT-1:0] pred_mask,
  input  logic             flag_bit,
  input  logic             sense,
  output logic [NSLOT-1:0] exec_en
);
  logic cond_true;
  assign cond_true = flag_bit ^ sense;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign exec_en[g] = issue_mask[g] & (~pred_mask[g] | cond_true);
  end
endmodule

// File: rtl/slot_issue_grouper.sv
module slot_issue_grouper
  import sig_pkg::*;
#(
  parameter int NSLOT = 7,
  parameter int NFLAG = 16,
  localparam int SEL_W = $clog2(NFLAG),
  localparam int CNT_W = $clog2(NSLOT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             serial_mode,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [NSLOT-1:0] hdr_break,
  input  logic [SEL_W-1:0] hdr_flag_sel,
  input  logic [NSLOT-1:0] hdr_pred,
  input  logic             hdr_sense,
  input  logic [CNT_W-1:0] hdr_decode,
  input  logic [NFLAG-1:0] flags,
  output logic             issue_valid,
  output logic [NSLOT-1:0] issue_mask,
  output logic [NSLOT-1:0] exec_en,
  output logic             done
);
  sig_state_e       state_q, state_d;
  logic [CNT_W-1:0] ptr_q, ptr_d;
  logic [CNT_W-1:0] limit_q, limit_n;
  logic [NSLOT-1:0] brk_q, pred_q;
  logic             flag_q, sense_q, serial_q;
  logic             load_en;
  logic             accept;

  logic [NSLOT-1:0] span_mask;
  logic [CNT_W-1:0] span_next;
  logic             span_last;

  assign accept  = in_valid && in_ready;
  assign limit_n = (hdr_decode >= CNT_W'(NSLOT)) ? '0 : (CNT_W'(NSLOT) - hdr_decode);

  sig_group_span #(.NSLOT(NSLOT), .CNT_W(CNT_W)) u_span (
    .start_ptr (ptr_q),
    .limit     (limit_q),
    .brk       (brk_q),
    .serial    (serial_q),
    .mask      (span_mask),
    .next_ptr  (span_next),
    .last      (span_last)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    load_en = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          load_en = 1'b1;
          ptr_d   = '0;
          state_d = (limit_n == '0) ? ST_DONE : ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        ptr_d = span_next;
        if (span_last) state_d = ST_DONE;
      end
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
    end
  end

  // Header capture, enabled on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit_q  <= '0;
      brk_q    <= '0;
      pred_q   <= '0;
      flag_q   <= 1'b0;
      sense_q  <= 1'b0;
      serial_q <= 1'b0;
    end else if (load_en) begin
      limit_q  <= limit_n;
      brk_q    <= hdr_break;
      pred_q   <= hdr_pred;
      flag_q   <= flags[hdr_flag_sel];
      sense_q  <= hdr_sense;
      serial_q <= serial_mode;
    end
  end

  assign in_ready    = (state_q == ST_IDLE);
  assign issue_valid = (state_q == ST_ISSUE);
  assign done        = (state_q == ST_DONE);
  assign issue_mask  = issue_valid ? span_mask : '0;

  sig_pred_gate #(.NSLOT(NSLOT)) u_gate (
    .issue_mask (issue_mask),
    .pred_mask  (pred_q),
    .flag_bit   (flag_q),
    .sense      (sense_q),
    .exec_en    (exec_en)
  );

  // Checks
  a_r4_group_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> (issue_mask != '0));

  a_r7_exec_within_group: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en & ~issue_mask) == '0);

  a_r6_serial_single: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && serial_q) |-> $onehot(issue_mask));

  a_r5_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> ((issue_mask >> limit_q) == '0));

  a_r3_break_only_leads: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> ((issue_mask & brk_q & ~(issue_mask & (~issue_mask + 1'b1))) == '0));

  a_r9_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> in_ready);

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
endmodule

// File: tb/slot_issue_grouper_test.sv
`timescale 1ns/1ps
module slot_issue_grouper_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        serial_mode = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [6:0]  hdr_break = '0;
  logic [3:0]  hdr_flag_sel = '0;
  logic [6:0]  hdr_pred = '0;
  logic        hdr_sense = 1'b0;
  logic [2:0]  hdr_decode = '0;
  logic [15:0] flags = '0;
  logic        issue_valid;
  logic [6:0]  issue_mask;
  logic [6:0]  exec_en;
  logic        done;

  int checks = 0;
  int errors = 0;
  bit running = 1'b0;
  bit finished = 1'b0;
  bit done_prev = 1'b0;

  typedef struct {
    logic [6:0] mask;
    logic [6:0] exec;
    bit         is_done;
    string      tag;
  } exp_t;
  exp_t sbq[$];

  always #2.5 clk = ~clk;

  slot_issue_grouper uut (
    .clk(clk), .rst_n(rst_n), .serial_mode(serial_mode), .in_valid(in_valid),
    .in_ready(in_ready), .hdr_break(hdr_break), .hdr_flag_sel(hdr_flag_sel),
    .hdr_pred(hdr_pred), .hdr_sense(hdr_sense), .hdr_decode(hdr_decode),
    .flags(flags), .issue_valid(issue_valid), .issue_mask(issue_mask),
    .exec_en(exec_en), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Driver: computes the expected groups, then presents the header.
  task automatic run_block(input string tag, input logic [6:0] brk, input logic [6:0] pred,
                           input logic [3:0] sel, input bit sense, input logic [2:0] dec,
                           input logic [15:0] fl, input bit ser);
    int lim;
    int p;
    bit fbit;
    fbit = fl[sel];
    lim = 7 - int'(dec);
    p = 0;
    while (p < lim) begin
      exp_t it;
      int j;
      it.mask = '0;
      it.mask[p] = 1'b1;
      j = p + 1;
      while (j < lim && !ser && !brk[j]) begin
        it.mask[j] = 1'b1;
        j++;
      end
      it.exec = it.mask & (~pred | {7{fbit ^ sense}});
      it.is_done = 1'b0;
      it.tag = tag;
      sbq.push_back(it);
      p = j;
    end
    begin
      exp_t dn;
      dn.mask = '0; dn.exec = '0; dn.is_done = 1'b1; dn.tag = "R9";
      sbq.push_back(dn);
    end
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    hdr_break = brk; hdr_pred = pred; hdr_flag_sel = sel; hdr_sense = sense;
    hdr_decode = dec; flags = fl; serial_mode = ser; in_valid = 1'b1;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    flags = ~fl;          // R8: later flag changes must not matter
    serial_mode = ~ser;   // R6: serial mode is sampled at acceptance
    hdr_break = ~brk;
  endtask

  // Monitor and scoreboard
  always @(negedge clk) begin
    if (rst_n && running) begin
      if (done_prev)
        chk(in_ready == 1'b1, "R9", "ready after done", 16'(in_ready), 16'h1);
      if (issue_valid || done) begin
        if (sbq.size() == 0) begin
          chk(1'b0, "R4", "unexpected output", 16'(issue_mask), 16'h0);
        end else begin
          exp_t it;
          it = sbq.pop_front();
          if (it.is_done) begin
            chk(done && !issue_valid, "R9", "done pulse", {14'd0, done, issue_valid}, 16'h2);
          end else begin
            chk(issue_valid && !done, it.tag, "group valid", {14'd0, done, issue_valid}, 16'h1);
            chk(issue_mask == it.mask, it.tag, "issue_mask", 16'(issue_mask), 16'(it.mask));
            chk(exec_en == it.exec, it.tag, "exec_en", 16'(exec_en), 16'(it.exec));
            chk(in_ready == 1'b0, "R2", "ready while issuing", 16'(in_ready), 16'h0);
          end
        end
      end else if (!in_ready && sbq.size() != 0) begin
        chk(1'b0, "R4", "gap in group stream", 16'(issue_valid), 16'h1);
      end
      done_prev = done;
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R4 watchdog expired: actual pending=%0d expected 0", sbq.size());
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(in_ready == 1'b1, "R1", "in_ready", 16'(in_ready), 16'h1);
    chk(issue_valid == 1'b0, "R1", "issue_valid", 16'(issue_valid), 16'h0);
    chk(done == 1'b0, "R1", "done", 16'(done), 16'h0);
    chk(issue_mask == '0, "R1", "issue_mask", 16'(issue_mask), 16'h0);
    chk(exec_en == '0, "R1", "exec_en", 16'(exec_en), 16'h0);
    running = 1'b1;

    run_block("R3", 7'b0000000, 7'h00, 4'd0, 1'b0, 3'd0, 16'h0000, 1'b0); // one wide group
    run_block("R3", 7'b1111111, 7'h00, 4'd0, 1'b0, 3'd0, 16'h0000, 1'b0); // seven groups
    run_block("R3", 7'b0101010, 7'h00, 4'd0, 1'b0, 3'd0, 16'h0000, 1'b0); // pairs
    run_block("R3", 7'b0000001, 7'h00, 4'd0, 1'b0, 3'd0, 16'h0000, 1'b0); // bit 0 inert
    run_block("R5", 7'b0000100, 7'h00, 4'd0, 1'b0, 3'd3, 16'h0000, 1'b0); // four usable
    run_block("R5", 7'b0101010, 7'h7F, 4'd0, 1'b0, 3'd7, 16'hFFFF, 1'b0); // empty block
    run_block("R5", 7'b0000000, 7'h00, 4'd0, 1'b0, 3'd6, 16'h0000, 1'b0); // single slot
    run_block("R6", 7'b0000000, 7'h00, 4'd0, 1'b0, 3'd1, 16'h0000, 1'b1); // serial
    run_block("R7", 7'b0010000, 7'b1010101, 4'd5, 1'b0, 3'd0, 16'h0020, 1'b0);
    run_block("R7", 7'b0010000, 7'b1010101, 4'd5, 1'b0, 3'd0, 16'hFFDF, 1'b0);
    run_block("R7", 7'b0000000, 7'b0110011, 4'd15, 1'b1, 3'd0, 16'h7FFF, 1'b0);
    run_block("R7", 7'b0000000, 7'b0110011, 4'd15, 1'b1, 3'd0, 16'h8000, 1'b0);
    run_block("R8", 7'b1111111, 7'h7F, 4'd9, 1'b0, 3'd0, 16'h0200, 1'b0);
    run_block("R8", 7'b1001001, 7'h7F, 4'd2, 1'b1, 3'd2, 16'h0000, 1'b1);

    while (sbq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1 && !issue_valid && !done, "R2", "idle at end",
        {13'd0, done, issue_valid, in_ready}, 16'h1);
    finished = 1'b1;
    finish_run();
  end
endmodule